// File: doc/BRIEF.md
# Quasi-Bidirectional Port Controller

This block drives eight general-purpose pins from a single 8-bit output latch. There is no direction register. A latch bit of 1 leaves its pin weakly pulled high, so the pin can serve as an input or as a soft high output. A latch bit of 0 switches on a strong sink that holds the pin low.

When a byte carrying ones is written, the block can add a short strong pull-up on those pins. This helps a heavily loaded line rise quickly. The boost lasts only for the high phase of the serial acknowledge clock that follows the written byte.

The serial interface logic feeds the block three things: the received byte, a one-cycle write strobe, and a level that is high while SCL is high during the acknowledge bit. The block returns per-pin drive enables for the pad cells. It also returns a synchronized copy of the actual pin levels, which is what a port read returns and what interrupt logic compares against.

Top module: `qbio_port`

## Requirements
- R1: While reset is active and after it is released, the latch holds all ones: `sinkEn` is 0x00, `weakPuEn` is 0xFF, `accelEn` is 0x00 and `pinSync` is 0xFF.
- R2: A byte presented on `wrData` with `wrStrobe` high at a rising clock edge is loaded into the latch. From that edge on, `sinkEn` equals the bitwise inverse of the byte and `weakPuEn` equals the byte.
- R3: A sink enabled by a written 0 stays on through any number of acknowledge phases and is released only by a later write of 1 to that bit.
- R4: After a write, while `ackSclHigh` is high, `accelEn` equals the written byte. Only bits written as 1 are boosted, and `accelEn` follows `ackSclHigh` combinationally.
- R5: `accelEn` is 0x00 whenever `ackSclHigh` is low. It is also 0x00 during an acknowledge high phase that has no write since the previous acknowledge phase ended.
- R6: The weak pull-up of a pin is off whenever its latch bit is 0.
- R7: For no pin is the sink enabled together with either the weak pull-up or the accelerator.
- R8: `pinSync` equals `pinIn` delayed by exactly two clock edges.
- R9: Bit i of the written byte controls pin i only, for i = 0 to 7.
- R10: `pinSync` reports the real pin level, not the latch. A pin written 1 but pulled low externally reads 0, and a sunk pin reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrStrobe | input | 1 | One-cycle pulse: load `wrData` into the latch |
| wrData | input | 8 | Byte received from the serial interface |
| ackSclHigh | input | 1 | High while SCL is high during the acknowledge bit |
| pinIn | input | 8 | Resolved pin levels |
| sinkEn | output | 8 | Strong pull-down enable per pin |
| weakPuEn | output | 8 | Weak pull-up enable per pin |
| accelEn | output | 8 | Transient strong pull-up enable per pin |
| pinSync | output | 8 | Pin levels after the two-flop synchronizer |

## Verification
The bench builds the block at its default width of eight pins with a two-stage synchronizer. This small size lets it sweep all 256 latch values.

For each value, the bench checks:
- the sink and weak pull-up enables;
- the accelerator enable during an acknowledge phase that follows a write;
- its absence during a second acknowledge phase with no write;
- the read-back level through a modelled open-drain pin.

Separate scenarios cover:
- the exact two-edge latency of the synchronizer;
- sink persistence across acknowledge phases with no write;
- one-hot bit mapping;
- an externally pulled-low pin whose latch bit is 1.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
  typedef struct packed {
    logic loadLatch;
    logic armAccel;
    logic endAccel;
  } qbpStrobe_t;
endpackage

// File: rtl/qbp_ctrl.sv
module qbp_ctrl
  import qbp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStrobe,
  input  logic       ackSclHigh,
  output qbpStrobe_t strobes,
  output logic       accelWindow
);
  logic ackPrev;
  logic accelArmed;

  always_comb begin
    strobes.loadLatch = wrStrobe;
    strobes.armAccel  = wrStrobe;
    strobes.endAccel  = ackPrev & ~ackSclHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackPrev    <= 1'b0;
      accelArmed <= 1'b0;
    end else begin
      ackPrev <= ackSclHigh;
      if (strobes.armAccel)      accelArmed <= 1'b1;
      else if (strobes.endAccel) accelArmed <= 1'b0;
    end
  end

  assign accelWindow = accelArmed & ackSclHigh;

  // R5: boost window only exists while SCL is high in the acknowledge bit
  p_window_needs_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    accelWindow |-> ackSclHigh);

  // R5: once an acknowledge phase ends with no new write, the next cannot boost
  p_window_closes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.endAccel && !wrStrobe) |=> !accelArmed || $past(wrStrobe));
endmodule

// File: rtl/qbp_datapath.sv
module qbp_datapath
  import qbp_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  qbpStrobe_t       strobes,
  input  logic [WIDTH-1:0] wrData,
  input  logic             accelWindow,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] sinkEn,
  output logic [WIDTH-1:0] weakPuEn,
  output logic [WIDTH-1:0] accelEn,
  output logic [WIDTH-1:0] pinSync
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [WIDTH-1:0] portLatch;
  logic [WIDTH-1:0] syncChain [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  portLatch <= '1;
    else if (strobes.loadLatch) portLatch <= wrData;
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= '1;
        else if (s == 0) syncChain[s] <= pinIn;
        else syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_pin
      assign sinkEn[b]   = ~portLatch[b];
      assign weakPuEn[b] = portLatch[b];
      assign accelEn[b]  = portLatch[b] & accelWindow;
    end
  endgenerate

  assign pinSync = syncChain[LAST_STAGE];

  // R7: sink never fights a pull-up on the same pin
  p_sink_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sinkEn & (weakPuEn | accelEn)) == '0);

  // R3: the latch changes only on a write strobe
  p_latch_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadLatch |=> $stable(portLatch));

  // R4: a boosted pin is one whose latch bit is 1
  p_accel_subset_r4: assert property (@(posedge clk) disable iff (!rstN)
    (accelEn & ~weakPuEn) == '0);

  logic [1:0] cyclesUp;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cyclesUp <= '0;
    else if (cyclesUp != 2'd3) cyclesUp <= cyclesUp + 2'd1;
  end

  // R8: synchronizer latency of two edges (default configuration)
  p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rstN)
    (SYNC_STAGES == 2 && cyclesUp >= 2'd2) |-> pinSync == $past(pinIn, 2));
endmodule

// File: rtl/qbio_port.sv
module qbio_port
  import qbp_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStrobe,
  input  logic [WIDTH-1:0] wrData,
  input  logic             ackSclHigh,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] sinkEn,
  output logic [WIDTH-1:0] weakPuEn,
  output logic [WIDTH-1:0] accelEn,
  output logic [WIDTH-1:0] pinSync
);
  qbpStrobe_t strobes;
  logic       accelWindow;

  qbp_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrStrobe   (wrStrobe),
    .ackSclHigh (ackSclHigh),
    .strobes    (strobes),
    .accelWindow(accelWindow)
  );

  qbp_datapath #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (wrData),
    .accelWindow(accelWindow),
    .pinIn      (pinIn),
    .sinkEn     (sinkEn),
    .weakPuEn   (weakPuEn),
    .accelEn    (accelEn),
    .pinSync    (pinSync)
  );
endmodule

// File: tb/qbio_port_tb_top.sv
module qbio_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = '0;
  logic       ackSclHigh = 1'b0;
  logic [7:0] extLow = '0;
  logic [7:0] pinIn;
  logic [7:0] sinkEn, weakPuEn, accelEn, pinSync;
  int         nRun = 0;
  int         nFail = 0;
  bit         finished = 1'b0;

  // open-drain pin model: low if sunk or externally pulled low
  assign pinIn = ~sinkEn & ~extLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  qbio_port dut_i (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrData(wrData),
    .ackSclHigh(ackSclHigh), .pinIn(pinIn), .sinkEn(sinkEn),
    .weakPuEn(weakPuEn), .accelEn(accelEn), .pinSync(pinSync)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] v);
    @(negedge clk); wrData = v; wrStrobe = 1'b1;
    @(negedge clk); wrStrobe = 1'b0; #1;
  endtask

  task automatic ackPulse(input string req, input logic [7:0] expAccel);
    @(negedge clk); ackSclHigh = 1'b1; #1;
    chk(req, accelEn, expAccel);
    @(negedge clk); ackSclHigh = 1'b0; #1;
    chk("R5 accel off with ack low", accelEn, 8'h00);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sink in reset", sinkEn, 8'h00);
    chk("R1 weak in reset", weakPuEn, 8'hFF);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R1 sink after reset", sinkEn, 8'h00);
    chk("R1 weak after reset", weakPuEn, 8'hFF);
    chk("R1 accel after reset", accelEn, 8'h00);
    chk("R1 pinSync after reset", pinSync, 8'hFF);
    ackPulse("R5 no boost without write", 8'h00);

    // exhaustive latch sweep
    for (int v = 0; v < 256; v++) begin
      doWrite(8'(v));
      chk("R2 sink", sinkEn, ~8'(v));
      chk("R2 weak", weakPuEn, 8'(v));
      chk("R6 weak off where latch 0", weakPuEn & ~8'(v), 8'h00);
      chk("R7 exclusion", sinkEn & (weakPuEn | accelEn), 8'h00);
      ackPulse("R4 boost follows write", 8'(v));
      ackPulse("R5 no boost on later ack", 8'h00);
      chk("R10 read equals pin level", pinSync, 8'(v));
    end

    // R9 one-hot mapping
    for (int i = 0; i < 8; i++) begin
      doWrite(~(8'h01 << i));
      chk("R9 one-hot sink", sinkEn, 8'h01 << i);
      repeat (2) @(negedge clk); #1;
      chk("R9 one-hot read", pinSync, ~(8'h01 << i));
    end

    // R3 sink persistence
    doWrite(8'h0F);
    ackPulse("R4 boost low nibble", 8'h0F);
    ackPulse("R5 idle ack", 8'h00);
    ackPulse("R5 idle ack", 8'h00);
    chk("R3 sink persists", sinkEn, 8'hF0);
    doWrite(8'hFF);
    chk("R3 sink released by 1", sinkEn, 8'h00);

    // R8 exact latency
    repeat (3) @(negedge clk);
    extLow = 8'h5A;
    @(negedge clk); #1;
    chk("R8 one edge: old value", pinSync, 8'hFF);
    @(negedge clk); #1;
    chk("R8 two edges: new value", pinSync, 8'hA5);

    // R10 external pull-down on an input pin plus sunk pins
    extLow = 8'h01;
    doWrite(8'h0F);
    repeat (2) @(negedge clk); #1;
    chk("R10 mixed read", pinSync, 8'h0E);
    extLow = 8'h00;

    finish_run();
  end
endmodule